// File: doc/BRIEF.md
# Supply Fault Supervisor

This block watches six supply comparators: undervoltage on the 5 V rail, the internal 3.3 V rail, the 12 V rail and the I/O rail, and overvoltage on the 5 V and 12 V rails. The comparator outputs are synchronized and gathered into a sticky monitor byte. While any fault is present, the block asks every power driver to go to high impedance. Three of the undervoltages always request a power-on reset. The 12 V undervoltage requests one only when a configuration bit allows it. The two overvoltages never request a reset.

A small register port gives read access to the monitor byte, a configuration byte and a monitor-select byte. A write of any data to the clear address wipes all monitor flags at once. A fault that is still present when the clear happens keeps its flag set.

A ready output shows that no reset-class fault has been seen for a set number of cycles. It is driven by a three-state sequencer:
- **HOLD**: entered on reset and whenever a reset-class fault is present.
- **COUNT**: entered from HOLD when no reset-class fault remains.
- **UP**: entered from COUNT when the count expires. It returns to HOLD on any reset-class fault, and COUNT does the same.

A general-purpose monitor pin outputs the OR of the selected flags when its enable bit is set.

Top module: `pwr_fault_supervisor`

## Requirements
- R1: Monitor byte at address 0x50. Bit 0 is 5 V under, bit 1 is 3.3 V under, bit 2 is 12 V under, bit 3 is I/O under, bit 4 is 5 V over, bit 5 is 12 V over, and bits 7:6 read 0. Each flag sets when its fault is seen and stays set after the fault goes away.
- R2: After reset, the monitor byte, the configuration byte (0x51) and the select byte (0x52) all read 0, and drv_hiz, por_req and gp_mon are low.
- R3: A write to address 0x77 clears every monitor flag. A write to any other address leaves the flags unchanged.
- R4: A fault that is still present during a clear write keeps its flag set.
- R5: drv_hiz is high exactly while any comparator input, delayed by two clocks, is high.
- R6: Undervoltage on the 5 V, 3.3 V or I/O rail raises por_req.
- R7: Undervoltage on the 12 V rail raises por_req only when configuration bit 0 is 0. When the bit is 1, the fault only latches its flag and raises drv_hiz.
- R8: The overvoltage faults raise drv_hiz but never por_req, and they do not drop rdy.
- R9: rdy is low after reset. It rises once no reset-class fault has been present for READY_DLY+1 cycles, and it is low in every cycle that follows a cycle with por_req high.
- R10: gp_mon is the OR of the monitor flags selected by bits 5:0 of the select byte, gated by configuration bit 1.
- R11: The configuration byte and the select byte read back the values written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low cold power-up reset |
| flt_raw | input | 6 | Comparator outputs, one per fault, in the R1 bit order |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| drv_hiz | output | 1 | Request to put all driver outputs into high impedance |
| por_req | output | 1 | Power-on reset request |
| rdy | output | 1 | Supply ready indication |
| gp_mon | output | 1 | General-purpose monitor output |

## Verification
Some properties are checked on every cycle. drv_hiz must follow the comparator inputs two clocks later. A flag may only drop in the cycle after a clear write. A clear made while no fault is present must empty the monitor byte. rdy must never be high right after a por_req cycle, and gp_mon must stay low while its enable bit is clear. Only the bench's scenarios can show the rest: which faults raise por_req under each setting of the 12 V bit, that rdy comes back after the delay, that flags survive writes to other addresses, and that the select mask works.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

    localparam int NFLT = 6;

    // flag bit positions inside the monitor byte
    localparam int F_UV5  = 0;
    localparam int F_UV33 = 1;
    localparam int F_UV12 = 2;
    localparam int F_UVIO = 3;
    localparam int F_OV5  = 4;
    localparam int F_OV12 = 5;

    // faults that always demand a power-on reset
    localparam logic [NFLT-1:0] HARD_RST_MASK =
        (NFLT'(1) << F_UV5) | (NFLT'(1) << F_UV33) | (NFLT'(1) << F_UVIO);

    // configuration byte bit positions
    localparam int CFG_UV12_NORST = 0;
    localparam int CFG_GP_EN      = 1;

    typedef enum logic [1:0] {
        RDY_HOLD  = 2'd0,
        RDY_COUNT = 2'd1,
        RDY_UP    = 2'd2
    } rdy_state_t;

endpackage

// File: rtl/pfs_sync.sv
module pfs_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[0] <= '0;
        else        pipe[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[i] <= '0;
            else        pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/pfs_fault_bank.sv
module pfs_fault_bank
    import pfs_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NFLT-1:0] live,
    input  logic            clr_stb,
    input  logic            uv12_norst,
    output logic [NFLT-1:0] flags,
    output logic            any_fault,
    output logic            rst_fault
);
    logic [NFLT-1:0] flags_q;
    logic            uv12_rst;

    // a clear reloads the live view, so a fault that persists is kept
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flags_q <= '0;
        else if (clr_stb) flags_q <= live;
        else              flags_q <= flags_q | live;
    end

    always_comb begin
        uv12_rst  = live[F_UV12] & ~uv12_norst;
        any_fault = |live;
        rst_fault = (|(live & HARD_RST_MASK)) | uv12_rst;
    end

    assign flags = flags_q;
endmodule

// File: rtl/pfs_ready_fsm.sv
module pfs_ready_fsm
    import pfs_pkg::*;
#(
    parameter int READY_DLY = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_fault,
    output logic rdy
);
    localparam int CW = (READY_DLY > 1) ? $clog2(READY_DLY) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(READY_DLY - 1);

    rdy_state_t   st_q, st_d;
    logic [CW-1:0] cnt_q;

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RDY_HOLD:  if (!rst_fault) st_d = RDY_COUNT;
            RDY_COUNT: begin
                if (rst_fault)              st_d = RDY_HOLD;
                else if (cnt_q == CNT_LAST) st_d = RDY_UP;
            end
            RDY_UP:    if (rst_fault) st_d = RDY_HOLD;
            default:   st_d = RDY_HOLD;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RDY_HOLD;
        else        st_q <= st_d;
    end

    // quiet-time counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= '0;
        else if (st_q != RDY_COUNT) cnt_q <= '0;
        else if (cnt_q != CNT_LAST) cnt_q <= cnt_q + 1'b1;
    end

    // outputs
    always_comb begin
        unique case (st_q)
            RDY_UP:  rdy = 1'b1;
            default: rdy = 1'b0;
        endcase
    end
endmodule

// File: rtl/pfs_regif.sv
module pfs_regif
    import pfs_pkg::*;
#(
    parameter logic [6:0] MON_ADDR = 7'h50,
    parameter logic [6:0] CFG_ADDR = 7'h51,
    parameter logic [6:0] SEL_ADDR = 7'h52,
    parameter logic [6:0] CLR_ADDR = 7'h77
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [6:0]      addr,
    input  logic [7:0]      wdata,
    input  logic [NFLT-1:0] flags,
    output logic [7:0]      rdata,
    output logic            clr_stb,
    output logic            uv12_norst,
    output logic            gp_en,
    output logic            gp_mon
);
    logic [7:0]      cfg_q;
    logic [NFLT-1:0] sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            sel_q <= '0;
        end else if (wr_en) begin
            if (addr == CFG_ADDR) cfg_q <= wdata;
            if (addr == SEL_ADDR) sel_q <= wdata[NFLT-1:0];
        end
    end

    always_comb begin
        clr_stb    = wr_en && (addr == CLR_ADDR);
        uv12_norst = cfg_q[CFG_UV12_NORST];
        gp_en      = cfg_q[CFG_GP_EN];
        gp_mon     = gp_en & (|(flags & sel_q));
        unique case (addr)
            MON_ADDR: rdata = 8'(flags);
            CFG_ADDR: rdata = cfg_q;
            SEL_ADDR: rdata = 8'(sel_q);
            default:  rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/pwr_fault_supervisor.sv
module pwr_fault_supervisor
    import pfs_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter int         READY_DLY   = 1024,
    parameter logic [6:0] MON_ADDR    = 7'h50,
    parameter logic [6:0] CFG_ADDR    = 7'h51,
    parameter logic [6:0] SEL_ADDR    = 7'h52,
    parameter logic [6:0] CLR_ADDR    = 7'h77
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [5:0] flt_raw,
    input  logic       reg_wr_en,
    input  logic [6:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       drv_hiz,
    output logic       por_req,
    output logic       rdy,
    output logic       gp_mon
);
    logic [NFLT-1:0] flt_live;
    logic [NFLT-1:0] flags_q;
    logic            clr_stb;
    logic            uv12_norst;
    logic            gp_en_w;
    logic            any_fault;
    logic            rst_fault;

    pfs_sync #(.W(NFLT), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(flt_raw), .q(flt_live)
    );

    pfs_fault_bank u_bank (
        .clk(clk), .rst_n(rst_n), .live(flt_live), .clr_stb(clr_stb),
        .uv12_norst(uv12_norst), .flags(flags_q),
        .any_fault(any_fault), .rst_fault(rst_fault)
    );

    pfs_ready_fsm #(.READY_DLY(READY_DLY)) u_fsm (
        .clk(clk), .rst_n(rst_n), .rst_fault(rst_fault), .rdy(rdy)
    );

    pfs_regif #(
        .MON_ADDR(MON_ADDR), .CFG_ADDR(CFG_ADDR),
        .SEL_ADDR(SEL_ADDR), .CLR_ADDR(CLR_ADDR)
    ) u_regif (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .flags(flags_q), .rdata(reg_rdata),
        .clr_stb(clr_stb), .uv12_norst(uv12_norst), .gp_en(gp_en_w),
        .gp_mon(gp_mon)
    );

    assign drv_hiz = any_fault;
    assign por_req = rst_fault;
endmodule

// File: rtl/pfs_checker.sv
module pfs_checker #(
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] CLR_ADDR    = 7'h77
) (
    input logic       clk,
    input logic       rst_n,
    input logic [5:0] flt_raw,
    input logic       reg_wr_en,
    input logic [6:0] reg_addr,
    input logic       drv_hiz,
    input logic       por_req,
    input logic       rdy,
    input logic       gp_mon,
    input logic [5:0] flags,
    input logic       gp_en
);
    logic [1:0] warm_q;
    logic       warm;
    logic       clr_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         warm_q <= '0;
        else if (!warm_q[1]) warm_q <= warm_q + 1'b1;
    end
    assign warm   = warm_q[1];
    assign clr_wr = reg_wr_en && (reg_addr == CLR_ADDR);

    // R5: output disable tracks the comparators two clocks later
    assert_hiz_tracks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && SYNC_STAGES == 2) |-> (drv_hiz == $past(|flt_raw, 2)));

    // R1: without a clear, no flag ever drops
    assert_flags_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr_wr) |-> ((flags & $past(flags)) == $past(flags)));

    // R3: a clear made while nothing is present empties the byte
    assert_clear_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_wr && !drv_hiz) |-> (flags == 6'd0));

    // R9: ready is never high right after a reset request
    assert_rdy_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(por_req) |-> !rdy);

    // R6: a reset request always comes with output disable
    assert_por_implies_hiz_R6: assert property (@(posedge clk) disable iff (!rst_n)
        por_req |-> drv_hiz);

    // R10: monitor pin silent while disabled
    assert_gp_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !gp_en |-> !gp_mon);
endmodule

bind pwr_fault_supervisor pfs_checker #(
    .SYNC_STAGES(SYNC_STAGES), .CLR_ADDR(CLR_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .flt_raw(flt_raw), .reg_wr_en(reg_wr_en),
    .reg_addr(reg_addr), .drv_hiz(drv_hiz), .por_req(por_req), .rdy(rdy),
    .gp_mon(gp_mon), .flags(flags_q), .gp_en(gp_en_w)
);

// File: tb/pwr_fault_supervisor_test.sv
`timescale 1ns/1ps
module pwr_fault_supervisor_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] flt_raw = '0;
    logic       reg_wr_en = 1'b0;
    logic [6:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       drv_hiz, por_req, rdy, gp_mon;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    localparam int DLY = 16;

    always #2 clk = ~clk;

    pwr_fault_supervisor #(.READY_DLY(DLY)) uut (
        .clk(clk), .rst_n(rst_n), .flt_raw(flt_raw), .reg_wr_en(reg_wr_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .drv_hiz(drv_hiz), .por_req(por_req), .rdy(rdy), .gp_mon(gp_mon)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        step(1);
        reg_wr_en = 1'b0; reg_addr = 7'h00;
    endtask

    task automatic rd(input logic [6:0] a, output logic [7:0] d);
        reg_addr = a; #0.1; d = reg_rdata;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(7'h50, v); check("R2 monitor", v, 8'h00);
        rd(7'h51, v); check("R2 config", v, 8'h00);
        rd(7'h52, v); check("R2 select", v, 8'h00);
        check("R2 hiz", 8'(drv_hiz), 8'h00);
        check("R2 por", 8'(por_req), 8'h00);
        check("R2 gp", 8'(gp_mon), 8'h00);
        check("R9 rdy at reset", 8'(rdy), 8'h00);
        step(5);
        check("R9 rdy early", 8'(rdy), 8'h00);
        step(DLY + 4);
        check("R9 rdy up", 8'(rdy), 8'h01);
    endtask

    task automatic t_each_fault;
        logic [7:0] v;
        for (int i = 0; i < 6; i++) begin
            flt_raw = 6'(1 << i);
            step(3);
            check("R5 hiz on", 8'(drv_hiz), 8'h01);
            // R6/R7/R8 classes with the 12 V bit at default 0
            check((i >= 4) ? "R8 no por" : "R6/R7 por", 8'(por_req),
                  (i >= 4) ? 8'h00 : 8'h01);
            flt_raw = '0;
            step(3);
            check("R5 hiz off", 8'(drv_hiz), 8'h00);
            rd(7'h50, v); check("R1 sticky flag", v, 8'(1 << i));
            wr(7'h77, 8'h00);
            rd(7'h50, v); check("R3 cleared", v, 8'h00);
        end
    endtask

    task automatic t_ready_cycle;
        step(DLY + 4);
        check("R9 rdy before", 8'(rdy), 8'h01);
        flt_raw = 6'b010000;
        step(4);
        check("R8 rdy kept on overvoltage", 8'(rdy), 8'h01);
        flt_raw = 6'b000001;
        step(3);
        check("R9 rdy drops", 8'(rdy), 8'h00);
        flt_raw = '0;
        step(5);
        check("R9 rdy waits", 8'(rdy), 8'h00);
        step(DLY + 2);
        check("R9 rdy returns", 8'(rdy), 8'h01);
        wr(7'h77, 8'h00);
    endtask

    task automatic t_uv12_norst;
        logic [7:0] v;
        wr(7'h51, 8'h01);
        step(DLY + 4);
        flt_raw = 6'b000100;
        step(3);
        check("R7 no por with bit set", 8'(por_req), 8'h00);
        check("R7 hiz with bit set", 8'(drv_hiz), 8'h01);
        step(3);
        check("R7 rdy kept", 8'(rdy), 8'h01);
        rd(7'h50, v); check("R7 flag latched", v, 8'h04);
        flt_raw = '0;
        step(3);
        wr(7'h51, 8'h00);
        wr(7'h77, 8'h00);
    endtask

    task automatic t_clear_rules;
        logic [7:0] v;
        flt_raw = 6'b000010;
        step(4);
        wr(7'h77, 8'hff);
        rd(7'h50, v); check("R4 held fault survives clear", v, 8'h02);
        flt_raw = '0;
        step(3);
        wr(7'h78, 8'hff);
        rd(7'h50, v); check("R3 other address ignored", v, 8'h02);
        wr(7'h50, 8'h00);
        rd(7'h50, v); check("R3 monitor write ignored", v, 8'h02);
        wr(7'h77, 8'h00);
        rd(7'h50, v); check("R3 clear after release", v, 8'h00);
    endtask

    task automatic t_gp_mon;
        logic [7:0] v;
        flt_raw = 6'b100000;
        step(3);
        flt_raw = '0;
        step(2);
        wr(7'h52, 8'h20);
        check("R10 gated off", 8'(gp_mon), 8'h00);
        wr(7'h51, 8'h02);
        check("R10 selected flag", 8'(gp_mon), 8'h01);
        wr(7'h52, 8'h01);
        check("R10 unselected flag", 8'(gp_mon), 8'h00);
        rd(7'h51, v); check("R11 config readback", v, 8'h02);
        rd(7'h52, v); check("R11 select readback", v, 8'h01);
        wr(7'h52, 8'h3f);
        check("R10 wide mask", 8'(gp_mon), 8'h01);
        wr(7'h77, 8'h00);
        check("R10 after clear", 8'(gp_mon), 8'h00);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_each_fault();
        t_ready_cycle();
        t_uv12_norst();
        t_clear_rules();
        t_gp_mon();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule